// File: doc/BRIEF.md
# Long-Press Reset Controller

This block turns a single active-low push-button into a system reset that fires only on a deliberate long hold. Brief presses never reach the reset output, so the same button can also serve as an ordinary interrupt source elsewhere on the chip. The hold time is chosen at run time from twenty steps. All timing is counted in pulses of a prescaled `tick` input rather than in raw clocks.

A build-time parameter picks how long reset lasts. In release-driven mode it lasts exactly as long as the button stays held. In fixed-width mode it lasts a set number of ticks whatever the button does, and a button still held afterwards does not fire again until it has been released.

A digital overvoltage flag stands in for an analog detector on the button pin. The first time the flag is seen, the block enters a test mode that stays set. It runs a short initial timer and then gives a confirmation reset. From then on every press uses the hold delay divided by 128. Only the power-on reset input leaves test mode. Output polarity is a parameter, and four status outputs expose the internal phase.

Top module: `longpress_reset`

## Requirements
- R1: After `por_n` has been low, `rst_out` is inactive, `st_idle` is 1, `st_test` is 0, and at most one of `st_idle`, `st_count` and `st_active` is ever 1.
- R2: With `tick` high every cycle and `hold_sel` = s, reset becomes active on the (s+1)*STEP_TICKS+3-th rising edge after `btn_n` falls. A `hold_sel` above 19 behaves as 19.
- R3: A press held low for (s+1)*STEP_TICKS rising edges and then released never activates reset. `st_count` is 1 while such a press is being timed.
- R4: In release-driven mode (FIXED_PULSE=0), reset stays active while the button is held and goes inactive on the third rising edge after `btn_n` returns high. There is no minimum width.
- R5: In fixed-width mode (FIXED_PULSE=1), reset is active for exactly PULSE_TICKS ticks. A button that is still held, or released and pressed again during the pulse, neither lengthens nor restarts the pulse, and a continuously held button does not fire reset again.
- R6: The hold counter advances only in cycles where `tick` is 1. With `tick` low, a held button never activates reset.
- R7: When `ovp_flag` rises outside test mode, `st_test` becomes 1 and reset becomes active on the INIT_TICKS+3-th rising edge. This holds even if a press is being timed. The confirmation pulse lasts PULSE_TICKS ticks in fixed-width mode. In release-driven mode it lasts until the third edge after `ovp_flag` falls.
- R8: In test mode the hold delay is ((s+1)*STEP_TICKS)>>7 ticks, with a minimum of 1, so reset becomes active on that count +3.
- R9: Test mode persists after `ovp_flag` and the button are released. Only `por_n` low clears it, and the next press then uses the full delay again.
- R10: With ACTIVE_HIGH=0, `rst_out` is low while reset is active. With ACTIVE_HIGH=1, it is high while reset is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; the only exit from test mode |
| tick | input | 1 | Prescaled timing enable, one pulse per time unit |
| btn_n | input | 1 | Push-button, active low, asynchronous |
| ovp_flag | input | 1 | Overvoltage detect on the button pin, asynchronous |
| hold_sel | input | SEL_W | Hold delay step, delay = (hold_sel+1)*STEP_TICKS |
| rst_out | output | 1 | Reset output, polarity set by ACTIVE_HIGH |
| st_idle | output | 1 | Waiting for a press |
| st_count | output | 1 | Timing a hold or the initial test timer |
| st_active | output | 1 | Reset currently active |
| st_test | output | 1 | Test mode latched |

## Verification
Two events can land in the same stretch of cycles: a press that is partway through its hold count and the arrival of the overvoltage flag. To provoke this, the bench holds the button with a long delay selected and raises the flag about a hundred cycles into the count. The result passes only if reset fires INIT_TICKS+3 edges after the flag rose, which is far earlier than the press alone could produce. Similarly, in fixed-width mode the button is released and pressed again during a running pulse, and the pulse width must stay exactly PULSE_TICKS.

// File: rtl/longpress_reset.sv
module longpress_reset #(
  parameter int STEP_TICKS  = 500,
  parameter int PULSE_TICKS = 210,
  parameter int INIT_TICKS  = 42,
  parameter int SEL_W       = 5,
  parameter int SEL_MAX     = 19,
  parameter int TEST_SHIFT  = 7,
  parameter bit FIXED_PULSE = 1'b0,
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tick,
  input  logic             btn_n,
  input  logic             ovp_flag,
  input  logic [SEL_W-1:0] hold_sel,
  output logic             rst_out,
  output logic             st_idle,
  output logic             st_count,
  output logic             st_active,
  output logic             st_test
);
  localparam int LONG_MAX = (SEL_MAX + 1) * STEP_TICKS;
  localparam int M1       = (LONG_MAX > PULSE_TICKS) ? LONG_MAX : PULSE_TICKS;
  localparam int CNT_MAX  = (M1 > INIT_TICKS) ? M1 : INIT_TICKS;
  localparam int CW       = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_CNT, S_ACT, S_WREL, S_INIT, S_IND} phase_t;

  phase_t          state;
  logic [CW-1:0]   cnt;
  logic            test_q;
  logic [1:0]      btn_sy, ovp_sy;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      btn_sy <= 2'b11;
      ovp_sy <= 2'b00;
    end else begin
      btn_sy <= {btn_sy[0], btn_n};
      ovp_sy <= {ovp_sy[0], ovp_flag};
    end
  end

  logic pressed, ovp_s;
  assign pressed = ~btn_sy[1];
  assign ovp_s   = ovp_sy[1];

  logic [SEL_W-1:0] sel_c;
  logic [CW-1:0]    full_lim, short_raw, short_lim, hold_lim, cnt_nx;
  assign sel_c     = (hold_sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : hold_sel;
  assign full_lim  = CW'((32'(sel_c) + 32'd1) * 32'(STEP_TICKS));
  assign short_raw = full_lim >> TEST_SHIFT;
  assign short_lim = (short_raw == '0) ? CW'(1) : short_raw;
  assign hold_lim  = test_q ? short_lim : full_lim;
  assign cnt_nx    = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      test_q <= 1'b0;
    end else if (ovp_s && !test_q) begin
      test_q <= 1'b1;
      state  <= S_INIT;
      cnt    <= '0;
    end else begin
      case (state)
        S_IDLE: if (pressed) begin state <= S_CNT; cnt <= '0; end
        S_CNT: begin
          if (!pressed) state <= S_IDLE;
          else if (tick) begin
            if (cnt_nx == hold_lim) begin state <= S_ACT; cnt <= '0; end
            else cnt <= cnt_nx;
          end
        end
        S_ACT, S_IND: begin
          if (FIXED_PULSE) begin
            if (tick) begin
              if (cnt_nx == CW'(PULSE_TICKS)) begin state <= S_WREL; cnt <= '0; end
              else cnt <= cnt_nx;
            end
          end else if (state == S_ACT) begin
            if (!pressed) state <= S_IDLE;
          end else if (!ovp_s) state <= S_WREL;
        end
        S_WREL: if (!pressed) state <= S_IDLE;
        S_INIT: begin
          if (tick) begin
            if (cnt_nx == CW'(INIT_TICKS)) begin state <= S_IND; cnt <= '0; end
            else cnt <= cnt_nx;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic act;
  assign act       = (state == S_ACT) || (state == S_IND);
  assign rst_out   = ACTIVE_HIGH ? act : ~act;
  assign st_idle   = (state == S_IDLE);
  assign st_count  = (state == S_CNT) || (state == S_INIT);
  assign st_active = act;
  assign st_test   = test_q;

  a_r1_status_onehot: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({st_idle, st_count, st_active}));

  a_r2_entry_from_held_tick: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_ACT && $past(state) == S_CNT) |-> ($past(pressed) && $past(tick)));

  a_r4_release_drops: assert property (@(posedge clk) disable iff (!por_n)
    (!FIXED_PULSE && state == S_ACT && !pressed && (test_q || !ovp_s)) |=> !act);

  a_r5_fixed_ignores_button: assert property (@(posedge clk) disable iff (!por_n)
    (FIXED_PULSE && state == S_ACT && !tick && (test_q || !ovp_s)) |=> state == S_ACT);

  a_r6_no_tick_no_advance: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_CNT && pressed && !tick && (test_q || !ovp_s)) |=> (state == S_CNT && $stable(cnt)));

  a_r9_test_sticky: assert property (@(posedge clk) disable iff (!por_n)
    test_q |=> test_q);
endmodule

// File: tb/tb_longpress_reset.sv
module tb_longpress_reset;
  localparam int STEP  = 128;
  localparam int PULSE = 20;
  localparam int INIT  = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0, tick = 1'b1, btn_n = 1'b1, ovp = 1'b0;
  logic [4:0] sel = '0;
  logic rst_r, idle_r, cnt_r, act_r_s, test_r;
  logic rst_f, idle_f, cnt_f, act_f_s, test_f;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  longpress_reset #(.STEP_TICKS(STEP), .PULSE_TICKS(PULSE), .INIT_TICKS(INIT),
    .FIXED_PULSE(1'b0), .ACTIVE_HIGH(1'b0)) dut (
    .clk(clk), .por_n(por_n), .tick(tick), .btn_n(btn_n), .ovp_flag(ovp),
    .hold_sel(sel), .rst_out(rst_r), .st_idle(idle_r), .st_count(cnt_r),
    .st_active(act_r_s), .st_test(test_r));

  longpress_reset #(.STEP_TICKS(STEP), .PULSE_TICKS(PULSE), .INIT_TICKS(INIT),
    .FIXED_PULSE(1'b1), .ACTIVE_HIGH(1'b1)) dut_fx (
    .clk(clk), .por_n(por_n), .tick(tick), .btn_n(btn_n), .ovp_flag(ovp),
    .hold_sel(sel), .rst_out(rst_f), .st_idle(idle_f), .st_count(cnt_f),
    .st_active(act_f_s), .st_test(test_f));

  logic act_r, act_f;
  assign act_r = ~rst_r;
  assign act_f = rst_f;

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_por();
    @(negedge clk) por_n = 1'b0;
    cyc(3);
    por_n = 1'b1;
    cyc(2);
  endtask

  task automatic long_press(input int s, input int exp_lat, input string req);
    int lat_r = -1, lat_f = -1, f_on = 0, rel = -1;
    @(negedge clk) sel = 5'(s);
    btn_n = 1'b0;
    for (int n = 1; n <= exp_lat + PULSE + 8; n++) begin
      @(negedge clk);
      if (act_r && lat_r < 0) lat_r = n;
      if (act_f && lat_f < 0) lat_f = n;
      if (act_f) f_on++;
    end
    chk(lat_r == exp_lat, {req, " latency release-mode"}, lat_r, exp_lat);
    chk(lat_f == exp_lat, {req, " latency fixed-mode"}, lat_f, exp_lat);
    chk(f_on == PULSE, "R5 fixed width while held", f_on, PULSE);
    chk(act_r == 1'b1, "R4 held keeps reset", int'(act_r), 1);
    btn_n = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (!act_r && rel < 0) rel = n;
    end
    chk(rel == 3, "R4 release latency", rel, 3);
    cyc(3);
  endtask

  task automatic short_press(input int s);
    int d = (s + 1) * STEP;
    int seen = 0, cnt_seen = 0;
    @(negedge clk) sel = 5'(s);
    btn_n = 1'b0;
    for (int n = 1; n <= d; n++) begin
      @(negedge clk);
      if (cnt_r) cnt_seen = 1;
    end
    btn_n = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (act_r || act_f) seen = 1;
    end
    chk(seen == 0, "R3 short press ignored", seen, 0);
    chk(cnt_seen == 1, "R3 counting status", cnt_seen, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, seen, f_on;
    cyc(3);
    // R1 / R10 reset state
    chk(rst_r == 1'b1 && rst_f == 1'b0, "R10 inactive polarity", int'({rst_r, rst_f}), 2);
    por_n = 1'b1;
    cyc(2);
    chk(idle_r && idle_f, "R1 idle after reset", int'({idle_r, idle_f}), 3);
    chk(!test_r && !test_f, "R1 test clear", int'({test_r, test_f}), 0);
    chk(!act_r && !act_f, "R1 reset inactive", int'({act_r, act_f}), 0);

    // R2 full sweep and R3 short presses
    for (int s = 0; s < 20; s++) begin
      long_press(s, (s + 1) * STEP + 3, "R2");
      short_press(s);
    end
    long_press(25, 20 * STEP + 3, "R2 clamp");

    // R10 active polarity
    @(negedge clk) sel = 5'd0;
    btn_n = 1'b0;
    cyc(STEP + 3);
    chk(rst_r == 1'b0 && rst_f == 1'b1, "R10 active polarity", int'({rst_r, rst_f}), 1);
    btn_n = 1'b1;
    cyc(PULSE + 5);

    // R6 tick gating
    @(negedge clk) tick = 1'b0;
    btn_n = 1'b0;
    seen = 0;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (act_r || act_f) seen = 1;
    end
    chk(seen == 0 && cnt_r == 1'b1, "R6 no tick no reset", seen, 0);
    tick = 1'b1;
    lat = -1;
    for (int n = 1; n <= STEP + 5; n++) begin
      @(negedge clk);
      if (act_r && lat < 0) lat = n;
    end
    chk(lat == STEP, "R6 count resumes on tick", lat, STEP);
    btn_n = 1'b1;
    cyc(PULSE + 5);

    // R5 fixed pulse ignores re-press, no retrigger while held
    @(negedge clk) btn_n = 1'b0;
    f_on = 0;
    seen = 0;
    for (int n = 1; n <= STEP + 3; n++) begin
      @(negedge clk);
      if (act_f) f_on++;
    end
    btn_n = 1'b1;
    cyc(4);
    f_on += 4;
    btn_n = 1'b0;
    for (int n = 1; n <= STEP + PULSE + 40; n++) begin
      @(negedge clk);
      if (act_f) f_on++;
    end
    chk(f_on == PULSE, "R5 re-press does not extend", f_on, PULSE);
    chk(act_f == 1'b0, "R5 held does not retrigger", int'(act_f), 0);
    btn_n = 1'b1;
    cyc(8);

    // R7 test entry with confirmation pulse
    @(negedge clk) ovp = 1'b1;
    lat = -1;
    f_on = 0;
    for (int n = 1; n <= INIT + PULSE + 10; n++) begin
      @(negedge clk);
      if (act_r && lat < 0) lat = n;
      if (act_f) f_on++;
    end
    chk(lat == INIT + 3, "R7 test entry latency", lat, INIT + 3);
    chk(f_on == PULSE, "R7 fixed confirmation width", f_on, PULSE);
    chk(test_r && test_f, "R7 test flag", int'({test_r, test_f}), 3);
    chk(act_r == 1'b1, "R7 release-mode follows flag", int'(act_r), 1);
    ovp = 1'b0;
    lat = -1;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (!act_r && lat < 0) lat = n;
    end
    chk(lat == 3, "R7 flag drop latency", lat, 3);
    cyc(5);
    chk(test_r && test_f, "R9 test sticky after flag clears", int'({test_r, test_f}), 3);

    // R8 shortened delays
    for (int s = 0; s < 20; s++) long_press(s, s + 1 + 3, "R8");
    chk(test_r && test_f, "R9 test sticky after presses", int'({test_r, test_f}), 3);

    // R9 power-on reset leaves test mode
    do_por();
    chk(!test_r && !test_f && idle_r, "R9 por clears test", int'({test_r, test_f}), 0);
    long_press(1, 2 * STEP + 3, "R9 full delay after exit");

    // R7 overvoltage during a hold count
    @(negedge clk) sel = 5'd5;
    btn_n = 1'b0;
    cyc(100);
    ovp = 1'b1;
    lat = -1;
    for (int n = 1; n <= INIT + 10; n++) begin
      @(negedge clk);
      if (act_r && lat < 0) lat = n;
    end
    chk(lat == INIT + 3, "R7 entry overrides count", lat, INIT + 3);
    ovp = 1'b0;
    btn_n = 1'b1;
    cyc(PULSE + 5);
    do_por();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule